// File: doc/BRIEF.md
# Mode S Address/Parity Serial Encoder

This block builds the closing 24-bit field of a Mode S uplink message one bit at a time. A message is opened by a one-cycle `start` pulse, which captures the 24-bit aircraft address and the short/long choice and clears a 24-stage remainder register. The data bits then arrive serially, most significant first, under a valid/ready pair. Each accepted bit is echoed unchanged on the output one cycle later and is also folded into the remainder register.

When the last data bit has been taken (32 for a short message, 88 for a long one), the input is closed. The block then emits 24 further bits on consecutive cycles. Each of these is the top of the remainder XORed with the matching address bit, taken from the top of the address down. The remainder shifts in zeros while these bits leave. A one-cycle `done` flag marks the final bit of the 56- or 112-bit message. The block drives a downstream modulator that takes one bit per `out_valid`.

Top module: `modes_parity_enc`

## Requirements
- R1: After reset, `out_valid`, `in_ready` and `done` are all 0.
- R2: In the cycle after a `start` pulse, `in_ready` is 1 and `out_valid` is 0.
- R3: A bit accepted (`in_valid` and `in_ready` high, `start` low) appears on `out_bit` with `out_valid` high in the following cycle, and its value is unchanged. Cycles with no accepted bit give `out_valid` 0 during the data phase.
- R4: `in_ready` stays high for exactly 32 accepted bits when `long_sel` was 0 at `start`, or 88 when it was 1. It is then low until the next `start`.
- R5: Directly after the last data bit, 24 bits follow on consecutive cycles. Output bit k (k=0..23) is bit 23-k of (R XOR A). R is the remainder of the data polynomial times x^24 divided by x^24+0xFFF409, where the first data bit is the highest power. A is the captured address.
- R6: `done` is high for one cycle, together with the 24th parity bit, and is never high at any other time.
- R7: `in_valid` and `in_bit` have no effect while `in_ready` is low, whether in the parity phase or when idle.
- R8: `start` takes priority in every state. It abandons any message in progress. A bit offered in the same cycle as `start` is not accepted.
- R9: Changes on `addr` and `long_sel` after the `start` cycle have no effect on the message being encoded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Opens a new message; captures `addr` and `long_sel` |
| long_sel | input | 1 | 1 selects 88 data bits, 0 selects 32 |
| addr | input | 24 | Aircraft address overlaid on the parity |
| in_valid | input | 1 | A data bit is offered |
| in_bit | input | 1 | Offered data bit |
| in_ready | output | 1 | Data phase open; bit is taken when `in_valid` is high |
| out_valid | output | 1 | `out_bit` holds a message bit |
| out_bit | output | 1 | Serial message bit, data then address/parity |
| done | output | 1 | Marks the last bit of the message |

## Verification
Two events can meet in one cycle: a `start` pulse and a data bit offered with `in_valid`. A `start` can also land in the middle of a message. The bench aborts messages partway through the data phase. It raises `start` together with `in_valid` and then sends a full new message. The judgement is that no output appears in the cycle after `start`, and that the new message's parity matches a model in which the abandoned bits and the colliding bit never existed.

// File: rtl/mse_pkg.sv
package mse_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DATA = 2'd1,
        ST_PAR  = 2'd2
    } mse_state_e;

    // Generator taps below the x^24 term
    localparam logic [23:0] MSE_POLY_DEFAULT = 24'hFFF409;

endpackage

// File: rtl/mse_crc_step.sv
// One step of the remainder register: either folds a message bit in
// (feed_i = 1) or shifts a zero through without feedback (feed_i = 0).
module mse_crc_step #(
    parameter int              W    = 24,
    parameter logic [W-1:0]    POLY = 24'hFFF409
) (
    input  logic [W-1:0] rem_i,
    input  logic         in_bit_i,
    input  logic         feed_i,
    output logic [W-1:0] rem_o
);
    logic fb;

    assign fb = feed_i & (rem_i[W-1] ^ in_bit_i);

    assign rem_o[0] = fb & POLY[0];

    for (genvar i = 1; i < W; i++) begin : g_tap
        assign rem_o[i] = rem_i[i-1] ^ (fb & POLY[i]);
    end
endmodule

// File: rtl/mse_addr_pick.sv
// Selects address bit W-1-idx (address leaves top bit first).
module mse_addr_pick #(
    parameter int W     = 24,
    parameter int CNT_W = 7
) (
    input  logic [W-1:0]     addr_i,
    input  logic [CNT_W-1:0] idx_i,
    output logic             bit_o
);
    always_comb begin
        bit_o = 1'b0;
        for (int i = 0; i < W; i++) begin
            if (idx_i == CNT_W'(i)) begin
                bit_o = addr_i[W-1-i];
            end
        end
    end
endmodule

// File: rtl/modes_parity_enc.sv
module modes_parity_enc #(
    parameter int          CRC_W      = 24,
    parameter int          SHORT_DATA = 32,
    parameter int          LONG_DATA  = 88,
    parameter logic [23:0] POLY       = mse_pkg::MSE_POLY_DEFAULT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             long_sel,
    input  logic [CRC_W-1:0] addr,
    input  logic             in_valid,
    input  logic             in_bit,
    output logic             in_ready,
    output logic             out_valid,
    output logic             out_bit,
    output logic             done
);
    import mse_pkg::*;

    localparam int MAX_CNT = (LONG_DATA > CRC_W) ? LONG_DATA : CRC_W;
    localparam int CNT_W   = $clog2(MAX_CNT + 1);
    localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_DATA - 1);
    localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_DATA - 1);
    localparam logic [CNT_W-1:0] PAR_LAST   = CNT_W'(CRC_W - 1);

    typedef struct packed {
        mse_state_e       st;
        logic [CRC_W-1:0] rem;
        logic [CRC_W-1:0] addr;
        logic             lng;
        logic [CNT_W-1:0] cnt;
        logic             ov;
        logic             ob;
        logic             dn;
    } enc_state_t;

    enc_state_t s_d, s_q;

    logic [CRC_W-1:0] rem_next;
    logic             addr_bit;
    logic [CNT_W-1:0] data_last;

    mse_crc_step #(
        .W    (CRC_W),
        .POLY (CRC_W'(POLY))
    ) u_step (
        .rem_i    (s_q.rem),
        .in_bit_i (in_bit),
        .feed_i   (s_q.st == ST_DATA),
        .rem_o    (rem_next)
    );

    mse_addr_pick #(
        .W     (CRC_W),
        .CNT_W (CNT_W)
    ) u_pick (
        .addr_i (s_q.addr),
        .idx_i  (s_q.cnt),
        .bit_o  (addr_bit)
    );

    assign data_last = s_q.lng ? LONG_LAST : SHORT_LAST;

    always_comb begin
        s_d    = s_q;
        s_d.ov = 1'b0;
        s_d.dn = 1'b0;
        if (start) begin
            s_d.st   = ST_DATA;
            s_d.rem  = '0;
            s_d.addr = addr;
            s_d.lng  = long_sel;
            s_d.cnt  = '0;
        end else begin
            unique case (s_q.st)
                ST_DATA: begin
                    if (in_valid) begin
                        s_d.ov  = 1'b1;
                        s_d.ob  = in_bit;
                        s_d.rem = rem_next;
                        if (s_q.cnt == data_last) begin
                            s_d.cnt = '0;
                            s_d.st  = ST_PAR;
                        end else begin
                            s_d.cnt = s_q.cnt + 1'b1;
                        end
                    end
                end
                ST_PAR: begin
                    s_d.ov  = 1'b1;
                    s_d.ob  = s_q.rem[CRC_W-1] ^ addr_bit;
                    s_d.rem = rem_next;
                    if (s_q.cnt == PAR_LAST) begin
                        s_d.cnt = '0;
                        s_d.st  = ST_IDLE;
                        s_d.dn  = 1'b1;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign in_ready  = (s_q.st == ST_DATA);
    assign out_valid = s_q.ov;
    assign out_bit   = s_q.ob;
    assign done      = s_q.dn;

endmodule

// File: rtl/mse_checker.sv
module mse_checker #(
    parameter int SHORT_DATA = 32,
    parameter int LONG_DATA  = 88
) (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic long_sel,
    input logic in_valid,
    input logic in_bit,
    input logic in_ready,
    input logic out_valid,
    input logic out_bit,
    input logic done
);
    localparam int AW = $clog2(LONG_DATA + 2);

    logic [AW-1:0] acc_q;
    logic          lng_q;
    logic [AW-1:0] lim;

    assign lim = lng_q ? AW'(LONG_DATA) : AW'(SHORT_DATA);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
            lng_q <= 1'b0;
        end else if (start) begin
            acc_q <= '0;
            lng_q <= long_sel;
        end else if (in_valid && in_ready) begin
            acc_q <= acc_q + 1'b1;
        end
    end

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !in_ready && !done));

    p_start_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (in_ready && !out_valid && !done));

    p_echo_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !start) |=> (out_valid && (out_bit == $past(in_bit))));

    p_ready_limit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (acc_q < lim));

    p_parity_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_ready && out_valid && !done && !start) |=> out_valid);

    p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (out_valid && acc_q == lim));

    p_idle_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_ready && !out_valid && !start) |=> !out_valid);

    p_start_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && in_valid) |=> !out_valid);

endmodule

bind modes_parity_enc mse_checker #(
    .SHORT_DATA (SHORT_DATA),
    .LONG_DATA  (LONG_DATA)
) u_chk (.*);

// File: tb/modes_parity_enc_bench.sv
`timescale 1ns/1ps
module modes_parity_enc_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        long_sel = 1'b0;
    logic [23:0] addr = '0;
    logic        in_valid = 1'b0;
    logic        in_bit = 1'b0;
    logic        in_ready, out_valid, out_bit, done;

    int    n_chk = 0;
    int    n_bad = 0;
    bit    finished = 1'b0;
    bit    exp_v = 1'b0;
    bit    exp_b = 1'b0;
    string tag = "R1";

    always #2 clk = ~clk;

    modes_parity_enc u_modes_parity_enc (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .long_sel  (long_sel),
        .addr      (addr),
        .in_valid  (in_valid),
        .in_bit    (in_bit),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_bit   (out_bit),
        .done      (done)
    );

    // Long division of data * x^24 by x^24 + 0xFFF409, then address overlay.
    function automatic logic [23:0] ref_par(logic [111:0] m, bit lng, logic [23:0] a);
        int          n = lng ? 88 : 32;
        logic [24:0] r = '0;
        for (int i = 0; i < n + 24; i++) begin
            logic b;
            b = (i < n) ? m[n-1-i] : 1'b0;
            r = {r[23:0], b};
            if (r[24]) r = r ^ 25'h1FFF409;
        end
        return r[23:0] ^ a;
    endfunction

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic cmp();
        chk(out_valid === exp_v, {tag, " out_valid"}, 32'(out_valid), 32'(exp_v));
        if (exp_v) chk(out_bit === exp_b, {tag, " out_bit"}, 32'(out_bit), 32'(exp_b));
    endtask

    task automatic run_msg(bit lng, logic [111:0] m, logic [23:0] a,
                           int gap_pct, int abort_at, bit junk_on_start);
        int          n = lng ? 88 : 32;
        int          i = 0;
        logic [23:0] par;
        @(negedge clk); cmp();
        start = 1'b1; long_sel = lng; addr = a;
        in_valid = junk_on_start; in_bit = 1'($urandom);
        exp_v = 1'b0; tag = "R8 start priority";
        @(negedge clk); cmp();
        chk(in_ready === 1'b1, "R2 in_ready after start", 32'(in_ready), 1);
        chk(done === 1'b0, "R6 done after start", 32'(done), 0);
        start = 1'b0;
        addr = 24'($urandom); long_sel = 1'($urandom);   // R9: ignored now
        while (i < n) begin
            if (i == abort_at) begin
                in_valid = 1'b0; exp_v = 1'b0;
                return;
            end
            chk(in_ready === 1'b1, "R4 in_ready during data", 32'(in_ready), 1);
            if (int'($urandom_range(99)) < gap_pct) begin
                in_valid = 1'b0; in_bit = 1'($urandom); exp_v = 1'b0;
            end else begin
                in_valid = 1'b1; in_bit = m[n-1-i]; exp_v = 1'b1; exp_b = in_bit; i++;
            end
            tag = "R3 echo";
            @(negedge clk); cmp();
        end
        par = ref_par(m, lng, a);
        for (int k = 0; k < 24; k++) begin
            chk(in_ready === 1'b0, "R4 in_ready low after data", 32'(in_ready), 0);
            in_valid = 1'($urandom); in_bit = 1'($urandom);   // R7: ignored
            exp_v = 1'b1; exp_b = par[23-k]; tag = "R5 parity bit";
            @(negedge clk); cmp();
            chk(done === (k == 23), "R6 done timing", 32'(done), 32'(k == 23));
        end
        in_valid = 1'b1; in_bit = 1'b1; exp_v = 1'b0; tag = "R7 idle input";
        @(negedge clk); cmp();
        chk(done === 1'b0, "R6 done single", 32'(done), 0);
        chk(in_ready === 1'b0, "R7 idle in_ready", 32'(in_ready), 0);
        in_valid = 1'b0;
    endtask

    function automatic logic [111:0] rnd_msg();
        return {$urandom, $urandom, $urandom, 16'($urandom)};
    endfunction

    initial begin
        void'($urandom(32'h5EED_0A17));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid === 1'b0, "R1 out_valid reset", 32'(out_valid), 0);
        chk(in_ready === 1'b0, "R1 in_ready reset", 32'(in_ready), 0);
        chk(done === 1'b0, "R1 done reset", 32'(done), 0);
        in_valid = 1'b1; in_bit = 1'b1; exp_v = 1'b0; tag = "R7 idle before start";
        @(negedge clk); cmp();
        in_valid = 1'b0;

        // Directed corners
        run_msg(1'b0, '0, 24'h000000, 0, -1, 1'b0);             // zero parity
        run_msg(1'b0, '0, 24'hFFFFFF, 0, -1, 1'b1);             // parity = address
        run_msg(1'b1, {112{1'b1}}, 24'hA5C33C, 0, -1, 1'b0);
        run_msg(1'b1, 112'h1, 24'h123456, 30, -1, 1'b1);        // lone last bit
        run_msg(1'b0, 112'h8000_0000, 24'h0, 0, -1, 1'b0);      // lone first bit
        // R8: abort mid-data, then start with a colliding bit
        run_msg(1'b1, rnd_msg(), 24'($urandom), 20, 40, 1'b0);
        run_msg(1'b0, rnd_msg(), 24'($urandom), 0, 31, 1'b1);
        run_msg(1'b0, 112'h0_F0F0_1234, 24'h0BEEF1, 10, -1, 1'b1);

        // Constrained random
        for (int t = 0; t < 60; t++) begin
            run_msg(1'($urandom), rnd_msg(), 24'($urandom),
                    int'($urandom_range(40)),
                    (t % 9 == 4) ? int'($urandom_range(31)) : -1,
                    1'($urandom));
        end
        @(negedge clk); cmp();

        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule